// File: doc/BRIEF.md
# Masked Keypad Interrupt Controller

This block keeps a record of which of up to sixteen keys are held down and turns key activity into a single active-low interrupt for a host. Key press and release events come in one per cycle. Each event carries a key index and a down flag. Every event updates one bit of a pressed-key bitmap. A mask register hides chosen keys from the interrupt. A masked key still appears in the bitmap that the host reads.

A two-bit mode field decides how a latched interrupt goes away. With mode bit 0 clear, the interrupt drops by itself once the last unmasked key is released. With mode bit 1 set, a read of the key-data register acknowledges the interrupt. A control write with its scan bit set always acknowledges it. The control register also stores a three-bit debounce value. This value is only stored and read back; the block does no matrix scanning and no debounce timing. When a key event and a register access fall in the same cycle, the event is applied first and the access acts on the updated state.

Top module: `kpd_irq_ctrl`

## Requirements
- R1: A key event sets (down flag 1) or clears (down flag 0) bit `idx` of the pressed bitmap. A read of the key-data register (select 0) returns that bitmap in bits 15:0. Writes to select 0 are ignored.
- R2: A press that leaves at least one unmasked key down latches the interrupt, and `kpd_irq_n` is low after the next clock edge. The interrupt only becomes latched through a press.
- R3: Mask register (select 2) bit i set hides key i from the interrupt. A press that leaves no unmasked key down does not raise the interrupt. The mask reads back as written.
- R4: When mode bit 0 is 0, any key event that leaves no unmasked key down clears the interrupt. When mode bit 0 is 1, releases leave the interrupt latched.
- R5: A key-data read clears a latched interrupt when mode bit 1 is 1. The read has no effect on the interrupt when mode bit 1 is 0.
- R6: A control write (select 1) stores the scan bit from bit 14 and the debounce value from bits 13:11. A control write with bit 14 set clears a latched interrupt; one with bit 14 clear leaves it latched.
- R7: A control read returns the interrupt in bit 15, (scan OR no key down) in bit 14, and debounce in bits 13:11. All other bits read 0.
- R8: The mode register (select 3) holds the mode in bits 15:14 and reads 0 in every other bit.
- R9: After reset: bitmap 0, mask 0, mode 3, scan 1, debounce 0, interrupt clear with `kpd_irq_n` high.
- R10: When a key event and a register access share a cycle, the event is applied first. A key-data read returns the bitmap that includes the event. A press together with a data read under mode bit 1 leaves the interrupt clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| key_evt_vld | input | 1 | Key event strobe |
| key_evt_idx | input | 4 | Index of the key in the event |
| key_evt_down | input | 1 | 1 = press, 0 = release |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | 0 key data, 1 control, 2 mask, 3 mode |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, combinational, reflects this cycle's event |
| kpd_irq_n | output | 1 | Active-low keypad interrupt |

## Verification
A corrupted bitmap bit shows up on the very next key-data read. It also shows up on the pin at the next press or release, because that edge decides whether the interrupt latches or drops. A wrong mode or mask bit stays hidden until an event or access depends on it. Then the pin goes wrong one clock later: it stays low after an acknowledge, drops too early on release, or stays high on an unmasked press. The tests therefore pair each setting with the event that exercises it and sample the pin on the cycle right after.

// File: rtl/kpd_pkg.sv
package kpd_pkg;
   localparam int REG_W    = 16;
   localparam int IRQ_BIT  = 15;
   localparam int SCAN_BIT = 14;
   localparam int DEB_LSB  = 11;
   localparam int DEB_W    = 3;
   localparam int MODE_LSB = 14;
   localparam int MODE_W   = 2;

   typedef enum logic [1:0] {
      SEL_DATA = 2'd0,
      SEL_CTRL = 2'd1,
      SEL_MASK = 2'd2,
      SEL_MODE = 2'd3
   } kpd_sel_e;
endpackage

// File: rtl/kpd_key_track.sv
module kpd_key_track #(
   parameter int NUM_KEYS = 16,
   parameter int IDX_W    = 4,
   parameter bit MASK_EN  = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                evt_vld,
   input  logic [IDX_W-1:0]    evt_idx,
   input  logic                evt_down,
   input  logic [NUM_KEYS-1:0] mask,
   output logic [NUM_KEYS-1:0] bitmap_nxt,
   output logic                any_live,
   output logic                any_down
);
   logic [NUM_KEYS-1:0] bitmap_q;
   logic [NUM_KEYS-1:0] live;

   for (genvar g = 0; g < NUM_KEYS; g++) begin : g_key
      assign bitmap_nxt[g] = (evt_vld && (evt_idx == IDX_W'(g))) ? evt_down : bitmap_q[g];
   end

   if (MASK_EN) begin : g_masked
      assign live = bitmap_nxt & ~mask;
   end else begin : g_unmasked
      logic unused_mask;
      assign unused_mask = ^mask;
      assign live = bitmap_nxt;
   end

   assign any_live = |live;
   assign any_down = |bitmap_nxt;

   always_ff @(posedge clk) begin
      if (!rst_n) bitmap_q <= '0;
      else        bitmap_q <= bitmap_nxt;
   end
endmodule

// File: rtl/kpd_irq_latch.sv
module kpd_irq_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic evt_vld,
   input  logic evt_down,
   input  logic any_live,
   input  logic auto_rel,
   input  logic ack,
   output logic irq_evt,
   output logic irq_q
);
   always_comb begin
      irq_evt = irq_q;
      if (evt_vld && evt_down && any_live)      irq_evt = 1'b1;
      else if (evt_vld && !any_live && auto_rel) irq_evt = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= irq_evt & ~ack;
   end
endmodule

// File: rtl/kpd_regfile.sv
module kpd_regfile
   import kpd_pkg::*;
#(
   parameter int NUM_KEYS = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                rd,
   input  logic                wr,
   input  logic [1:0]          sel,
   input  logic [REG_W-1:0]    wdata,
   input  logic [NUM_KEYS-1:0] bitmap_nxt,
   input  logic                any_down,
   input  logic                irq_evt,
   output logic [NUM_KEYS-1:0] mask_q,
   output logic [MODE_W-1:0]   mode_q,
   output logic                ack,
   output logic [REG_W-1:0]    rdata
);
   logic             scan_q;
   logic [DEB_W-1:0] deb_q;
   logic [REG_W-1:0] ctrl_rd;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         scan_q <= 1'b1;
         deb_q  <= '0;
         mask_q <= '0;
         mode_q <= 2'b11;
      end else if (wr) begin
         case (kpd_sel_e'(sel))
            SEL_CTRL: begin
               scan_q <= wdata[SCAN_BIT];
               deb_q  <= wdata[DEB_LSB +: DEB_W];
            end
            SEL_MASK: mask_q <= wdata[NUM_KEYS-1:0];
            SEL_MODE: mode_q <= wdata[MODE_LSB +: MODE_W];
            default:  ;
         endcase
      end
   end

   always_comb begin
      ctrl_rd                     = '0;
      ctrl_rd[IRQ_BIT]            = irq_evt;
      ctrl_rd[SCAN_BIT]           = scan_q | ~any_down;
      ctrl_rd[DEB_LSB +: DEB_W]   = deb_q;
   end

   always_comb begin
      rdata = '0;
      if (rd) begin
         case (kpd_sel_e'(sel))
            SEL_DATA: rdata = REG_W'(bitmap_nxt);
            SEL_CTRL: rdata = ctrl_rd;
            SEL_MASK: rdata = REG_W'(mask_q);
            SEL_MODE: rdata[MODE_LSB +: MODE_W] = mode_q;
            default:  rdata = '0;
         endcase
      end
   end

   assign ack = (rd && (kpd_sel_e'(sel) == SEL_DATA) && mode_q[1]) ||
                (wr && (kpd_sel_e'(sel) == SEL_CTRL) && wdata[SCAN_BIT]);
endmodule

// File: rtl/kpd_irq_ctrl.sv
module kpd_irq_ctrl
   import kpd_pkg::*;
#(
   parameter int NUM_KEYS = 16,
   parameter bit MASK_EN  = 1'b1,
   localparam int IDX_W   = (NUM_KEYS > 1) ? $clog2(NUM_KEYS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             key_evt_vld,
   input  logic [IDX_W-1:0] key_evt_idx,
   input  logic             key_evt_down,
   input  logic             reg_rd,
   input  logic             reg_wr,
   input  logic [1:0]       reg_sel,
   input  logic [REG_W-1:0] reg_wdata,
   output logic [REG_W-1:0] reg_rdata,
   output logic             kpd_irq_n
);
   if (NUM_KEYS < 1 || NUM_KEYS > REG_W) begin : g_bad_keys
      $error("NUM_KEYS must lie in 1..REG_W");
   end

   logic [NUM_KEYS-1:0] bitmap_nxt;
   logic [NUM_KEYS-1:0] mask_q;
   logic [MODE_W-1:0]   mode_q;
   logic                any_live, any_down, irq_evt, irq_q, ack;

   kpd_key_track #(.NUM_KEYS(NUM_KEYS), .IDX_W(IDX_W), .MASK_EN(MASK_EN)) u_track (
      .clk(clk), .rst_n(rst_n),
      .evt_vld(key_evt_vld), .evt_idx(key_evt_idx), .evt_down(key_evt_down),
      .mask(mask_q), .bitmap_nxt(bitmap_nxt), .any_live(any_live), .any_down(any_down)
   );

   kpd_irq_latch u_latch (
      .clk(clk), .rst_n(rst_n),
      .evt_vld(key_evt_vld), .evt_down(key_evt_down),
      .any_live(any_live), .auto_rel(~mode_q[0]), .ack(ack),
      .irq_evt(irq_evt), .irq_q(irq_q)
   );

   kpd_regfile #(.NUM_KEYS(NUM_KEYS)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .rd(reg_rd), .wr(reg_wr), .sel(reg_sel), .wdata(reg_wdata),
      .bitmap_nxt(bitmap_nxt), .any_down(any_down), .irq_evt(irq_evt),
      .mask_q(mask_q), .mode_q(mode_q), .ack(ack), .rdata(reg_rdata)
   );

   assign kpd_irq_n = ~irq_q;
endmodule

// File: rtl/kpd_irq_ctrl_chk.sv
module kpd_irq_ctrl_chk #(
   parameter int NUM_KEYS = 16,
   parameter int IDX_W    = 4
) (
   input logic                clk,
   input logic                rst_n,
   input logic                key_evt_vld,
   input logic [IDX_W-1:0]    key_evt_idx,
   input logic                key_evt_down,
   input logic                reg_rd,
   input logic                reg_wr,
   input logic [1:0]          reg_sel,
   input logic [15:0]         reg_wdata,
   input logic                kpd_irq_n,
   input logic [NUM_KEYS-1:0] bitmap_nxt,
   input logic [NUM_KEYS-1:0] mask_q,
   input logic [1:0]          mode_q
);
   logic rd_ack, wr_ack, no_live, evt_masked;
   assign rd_ack     = reg_rd && (reg_sel == 2'd0) && mode_q[1];
   assign wr_ack     = reg_wr && (reg_sel == 2'd1) && reg_wdata[14];
   assign no_live    = ((bitmap_nxt & ~mask_q) == '0);
   assign evt_masked = mask_q[key_evt_idx];

   AST_PRESS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (key_evt_vld && key_evt_down && !evt_masked && !rd_ack && !wr_ack) |=> !kpd_irq_n); // R2
   AST_RISE_FROM_PRESS: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(kpd_irq_n) |-> $past(key_evt_vld && key_evt_down)); // R2
   AST_MASKED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (key_evt_vld && key_evt_down && no_live && kpd_irq_n) |=> kpd_irq_n); // R3
   AST_AUTO_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (key_evt_vld && !key_evt_down && !mode_q[0] && no_live) |=> kpd_irq_n); // R4
   AST_READ_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      rd_ack |=> kpd_irq_n); // R5
   AST_SCAN_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ack |=> kpd_irq_n); // R6
endmodule

bind kpd_irq_ctrl kpd_irq_ctrl_chk #(.NUM_KEYS(NUM_KEYS), .IDX_W(IDX_W)) u_chk (
   .clk(clk), .rst_n(rst_n),
   .key_evt_vld(key_evt_vld), .key_evt_idx(key_evt_idx), .key_evt_down(key_evt_down),
   .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
   .kpd_irq_n(kpd_irq_n), .bitmap_nxt(bitmap_nxt), .mask_q(mask_q), .mode_q(mode_q)
);

// File: tb/kpd_irq_ctrl_bench.sv
module kpd_irq_ctrl_bench;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        key_evt_vld, key_evt_down, reg_rd, reg_wr;
   logic [3:0]  key_evt_idx;
   logic [1:0]  reg_sel;
   logic [15:0] reg_wdata, reg_rdata;
   logic        kpd_irq_n;
   int          checks = 0;
   int          errors = 0;
   bit          done = 0;

   always #10 clk = ~clk;

   kpd_irq_ctrl u_kpd_irq_ctrl (
      .clk(clk), .rst_n(rst_n),
      .key_evt_vld(key_evt_vld), .key_evt_idx(key_evt_idx), .key_evt_down(key_evt_down),
      .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .kpd_irq_n(kpd_irq_n)
   );

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Drive one cycle starting at a falling edge; read data sampled before the rising edge.
   task automatic cyc(input bit ev, input int idx, input bit dn, input bit rd, input bit wr,
                      input logic [1:0] sel, input logic [15:0] wd, output logic [15:0] rdv);
      key_evt_vld = ev; key_evt_idx = 4'(idx); key_evt_down = dn;
      reg_rd = rd; reg_wr = wr; reg_sel = sel; reg_wdata = wd;
      #2 rdv = reg_rdata;
      @(negedge clk);
      key_evt_vld = 0; key_evt_down = 0; reg_rd = 0; reg_wr = 0; reg_wdata = '0;
   endtask

   task automatic press(input int idx);
      logic [15:0] d; cyc(1, idx, 1, 0, 0, 2'd0, 16'h0, d);
   endtask
   task automatic release_key(input int idx);
      logic [15:0] d; cyc(1, idx, 0, 0, 0, 2'd0, 16'h0, d);
   endtask
   task automatic wreg(input logic [1:0] sel, input logic [15:0] v);
      logic [15:0] d; cyc(0, 0, 0, 0, 1, sel, v, d);
   endtask
   task automatic rreg(input logic [1:0] sel, output logic [15:0] v);
      cyc(0, 0, 0, 1, 0, sel, 16'h0, v);
   endtask

   task automatic t_reset;
      logic [15:0] v;
      chk("R9 pin after reset", {15'd0, kpd_irq_n}, 16'h1);
      rreg(2'd1, v); chk("R9/R7 control reset", v, 16'h4000);
      rreg(2'd2, v); chk("R9 mask reset", v, 16'h0000);
      rreg(2'd3, v); chk("R9/R8 mode reset", v, 16'hC000);
      rreg(2'd0, v); chk("R9 bitmap reset", v, 16'h0000);
   endtask

   task automatic t_bitmap;
      logic [15:0] v;
      press(3);
      chk("R2 press latches", {15'd0, kpd_irq_n}, 16'h0);
      press(10);
      wreg(2'd0, 16'hFFFF);
      rreg(2'd0, v); chk("R1 bitmap two keys, data write ignored", v, 16'h0408);
      chk("R5 data read acks in mode 3", {15'd0, kpd_irq_n}, 16'h1);
      release_key(3);
      rreg(2'd0, v); chk("R1 release clears bit", v, 16'h0400);
      release_key(10);
      rreg(2'd0, v); chk("R1 all released", v, 16'h0000);
   endtask

   task automatic t_mask;
      logic [15:0] v;
      wreg(2'd2, 16'h0020);
      rreg(2'd2, v); chk("R3 mask readback", v, 16'h0020);
      press(5);
      chk("R3 masked press silent", {15'd0, kpd_irq_n}, 16'h1);
      rreg(2'd0, v); chk("R1 masked key in bitmap", v, 16'h0020);
      press(6);
      chk("R3 unmasked press latches", {15'd0, kpd_irq_n}, 16'h0);
      release_key(5); release_key(6);
      wreg(2'd1, 16'h4000);
      chk("R6 scan write acks", {15'd0, kpd_irq_n}, 16'h1);
      wreg(2'd2, 16'h0000);
   endtask

   task automatic t_release_mode;
      logic [15:0] v;
      wreg(2'd3, 16'h0000);
      rreg(2'd3, v); chk("R8 mode 0 readback", v, 16'h0000);
      press(2);
      chk("R2 press in mode 0", {15'd0, kpd_irq_n}, 16'h0);
      rreg(2'd0, v);
      chk("R5 data read no ack when bit1=0", {15'd0, kpd_irq_n}, 16'h0);
      release_key(2);
      chk("R4 auto release with bit0=0", {15'd0, kpd_irq_n}, 16'h1);
      wreg(2'd3, 16'h4000);
      press(2); release_key(2);
      chk("R4 sticky with bit0=1", {15'd0, kpd_irq_n}, 16'h0);
      wreg(2'd1, 16'h4000);
      chk("R6 scan write acks sticky", {15'd0, kpd_irq_n}, 16'h1);
   endtask

   task automatic t_ctrl;
      logic [15:0] v;
      wreg(2'd1, 16'h2800);
      rreg(2'd1, v); chk("R7 scan0 debounce5 no keys", v, 16'h6800);
      press(1);
      rreg(2'd1, v); chk("R7 irq set, key down, scan0", v, 16'hA800);
      wreg(2'd1, 16'h0000);
      chk("R6 scan-clear write keeps irq", {15'd0, kpd_irq_n}, 16'h0);
      wreg(2'd1, 16'h7800);
      chk("R6 scan-set write acks", {15'd0, kpd_irq_n}, 16'h1);
      rreg(2'd1, v); chk("R7 scan1 debounce7 key down", v, 16'h7800);
      release_key(1);
   endtask

   task automatic t_order;
      logic [15:0] v;
      wreg(2'd3, 16'hC000);
      cyc(1, 7, 1, 1, 0, 2'd0, 16'h0, v);
      chk("R10 read sees same-cycle press", v, 16'h0080);
      chk("R10 press then read leaves irq clear", {15'd0, kpd_irq_n}, 16'h1);
      cyc(1, 7, 0, 1, 0, 2'd0, 16'h0, v);
      chk("R10 read sees same-cycle release", v, 16'h0000);
   endtask

   initial begin
      #4000000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      rst_n = 0; key_evt_vld = 0; key_evt_idx = '0; key_evt_down = 0;
      reg_rd = 0; reg_wr = 0; reg_sel = '0; reg_wdata = '0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_bitmap();
      t_mask();
      t_release_mode();
      t_ctrl();
      t_order();
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule